// File: doc/BRIEF.md
# Write-Invalidate Coherent Cache Cluster

This block joins several processor ports, each with its own small direct-mapped write-through cache, to one shared word-addressed memory over a single internal bus. Read hits are served from the local cache without touching the bus. Read misses and all writes compete for the bus, which carries one operation per cycle and is granted by fixed priority. Coherence is kept by invalidation: a write goes through to memory and, in the same cycle, removes the affected block from every other cache. The writer's own copy, if present, is patched in place. A write miss does not allocate a line.

Each port uses a simple handshake. The processor holds a request until ready is high, and a one-cycle response follows in the next cycle. The default build has three ports, 8-bit word addresses, 32-bit data, eight-word blocks and four lines per cache.

Top module: `coh_wt_cluster`

## Requirements
- R1: After reset every line of every cache is invalid and memory word i holds the value i (zero-extended), so the first read of any address is a miss.
- R2: A request is accepted in the cycle where req_valid and req_ready are both high; rsp_valid is high for exactly the following cycle, carrying the read data for reads and zero for writes.
- R3: A read miss needs the bus and installs the whole block of the requested word; a later read by the same port of any word in that block is a hit and is accepted in the same cycle even while the bus is granted to another port.
- R4: Several caches may hold the same block at once, and their read hits to it are accepted in the same cycle.
- R5: Every write updates memory, so a later read miss from any port returns the written value.
- R6: A write invalidates the written block in every other cache; their next read of it is a miss that returns the new value.
- R7: When the writing port holds the block, its copy is updated in place and stays valid, so its next read of that word hits and returns the new value.
- R8: A write miss does not allocate: the writer's next read of that block is a miss.
- R9: Invalidation is per block: a write to one word invalidates another cache's copy of a different word of the same eight-word block.
- R10: The bus grants at most one request per cycle, to the lowest-numbered port that needs it (a write or a read miss); port 0 with a write pending is always accepted.
- R11: When a read hit and another port's write to the same block fall in the same cycle, the hit returns the old value and the copy is then invalid.
- R12: The word address splits as offset in the low log2(LINE_WORDS) bits, line index in the next log2(NLINES) bits and tag in the rest; a read miss to a block with the same index and another tag replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Request pending, one bit per port |
| req_we | input | NCPU | 1 = write, 0 = read, per port |
| req_addr | input | NCPU x ADDR_W | Word address per port |
| req_wdata | input | NCPU x DATA_W | Write data per port |
| req_ready | output | NCPU | Request accepted this cycle |
| rsp_valid | output | NCPU | Response valid, one cycle after acceptance |
| rsp_rdata | output | NCPU x DATA_W | Read data (zero for writes) |

## Verification
Hit and miss are told apart at the ports by holding port 0 on a stream of writes to a block no one reads: a hit is accepted at once, a miss waits for the bus. With this probe, the bench runs cold reads, reads of other words in a filled block, reads shared by two caches, and writes from a foreign port, the own port and to uncached blocks. Together these separate allocation, in-place update, invalidation and write-through. Simultaneous writes from all ports expose the grant order. A write to a neighbouring word and a read of a conflicting tag separate block-granular invalidation from line replacement. A hit in the same cycle as a remote write pins down the ordering of local and bus operations.

// File: rtl/coh_wt_cluster.sv
module coh_wt_cluster #(
  parameter int NCPU       = 3,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NLINES     = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NCPU-1:0]                  req_valid,
  input  logic [NCPU-1:0]                  req_we,
  input  logic [NCPU-1:0][ADDR_W-1:0]      req_addr,
  input  logic [NCPU-1:0][DATA_W-1:0]      req_wdata,
  output logic [NCPU-1:0]                  req_ready,
  output logic [NCPU-1:0]                  rsp_valid,
  output logic [NCPU-1:0][DATA_W-1:0]      rsp_rdata
);
  localparam int OFF_W     = $clog2(LINE_WORDS);
  localparam int IDX_W     = $clog2(NLINES);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [NCPU-1:0][NLINES-1:0]            line_ok;
  logic [NCPU-1:0][NLINES-1:0][TAG_W-1:0] line_tag;
  logic [DATA_W-1:0] line_dat [NCPU][NLINES][LINE_WORDS];

  logic [NCPU-1:0] hit, want_bus, gnt;
  logic [NCPU-1:0][DATA_W-1:0] hit_word, mem_word;

  logic              bus_go, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;

  wire [TAG_W-1:0] btag = bus_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] bidx = bus_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] boff = bus_addr[OFF_W-1:0];

  for (genvar p = 0; p < NCPU; p++) begin : g_port
    wire [TAG_W-1:0] ptag = req_addr[p][ADDR_W-1 -: TAG_W];
    wire [IDX_W-1:0] pidx = req_addr[p][OFF_W +: IDX_W];
    wire [OFF_W-1:0] poff = req_addr[p][OFF_W-1:0];
    assign hit[p]       = line_ok[p][pidx] && (line_tag[p][pidx] == ptag);
    assign want_bus[p]  = req_valid[p] && (req_we[p] || !hit[p]);
    assign req_ready[p] = req_valid[p] && (want_bus[p] ? gnt[p] : 1'b1);
    assign hit_word[p]  = line_dat[p][pidx][poff];
    assign mem_word[p]  = mem[req_addr[p]];
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (want_bus[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (gnt[i]) begin
        bus_we    = req_we[i];
        bus_addr  = req_addr[i];
        bus_wdata = req_wdata[i];
      end
    end
  end

  assign bus_go = |gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= DATA_W'(i);
    end else if (bus_go && bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ok <= '0;
    end else if (bus_go) begin
      for (int p = 0; p < NCPU; p++) begin
        if (gnt[p] && !bus_we)
          line_ok[p][bidx] <= 1'b1;
        else if (!gnt[p] && bus_we && line_ok[p][bidx] && line_tag[p][bidx] == btag)
          line_ok[p][bidx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bus_go) begin
      for (int p = 0; p < NCPU; p++) begin
        if (gnt[p] && !bus_we) begin
          line_tag[p][bidx] <= btag;
          for (int w = 0; w < LINE_WORDS; w++)
            line_dat[p][bidx][w] <= mem[{btag, bidx, OFF_W'(w)}];
        end else if (gnt[p] && hit[p]) begin
          line_dat[p][bidx][boff] <= bus_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
    end else begin
      for (int p = 0; p < NCPU; p++) begin
        rsp_valid[p] <= req_ready[p];
        if (req_ready[p] && !req_we[p])
          rsp_rdata[p] <= hit[p] ? hit_word[p] : mem_word[p];
        else
          rsp_rdata[p] <= '0;
      end
    end
  end
endmodule

module coh_wt_cluster_chk #(
  parameter int NCPU   = 3,
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int NLINES = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NCPU-1:0]                  req_valid,
  input logic [NCPU-1:0]                  req_we,
  input logic [NCPU-1:0]                  req_ready,
  input logic [NCPU-1:0]                  gnt,
  input logic                             bus_we,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [NCPU-1:0][NLINES-1:0]      line_ok,
  input logic [NCPU-1:0][NLINES-1:0][TAG_W-1:0] line_tag
);
  wire [TAG_W-1:0] ctag = bus_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] cidx = bus_addr[OFF_W +: IDX_W];

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (line_ok == '0));

  p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  p_top_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_we[0]) |-> req_ready[0]);

  p_one_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_ready & req_we) <= 1);

  for (genvar j = 0; j < NCPU; j++) begin : g_chk
    p_inval_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt && bus_we && !gnt[j]) |=>
      !(line_ok[j][$past(cidx)] && line_tag[j][$past(cidx)] == $past(ctag)));

    p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[j] && !bus_we) |=> (line_ok[j][$past(cidx)] && line_tag[j][$past(cidx)] == $past(ctag)));
  end
endmodule

bind coh_wt_cluster coh_wt_cluster_chk #(
  .NCPU(NCPU), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .NLINES(NLINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_ready(req_ready),
  .gnt(gnt), .bus_we(bus_we), .bus_addr(bus_addr), .line_ok(line_ok), .line_tag(line_tag)
);

// File: tb/tb_coh_wt_cluster.sv
module tb_coh_wt_cluster;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] v = '0, we = '0;
  logic [2:0][7:0] ad = '0;
  logic [2:0][31:0] wd = '0;
  logic [2:0] rdy, rv;
  logic [2:0][31:0] rd;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] expm [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_wt_cluster dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_we(we), .req_addr(ad),
    .req_wdata(wd), .req_ready(rdy), .rsp_valid(rv), .rsp_rdata(rd)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic go(input int p, input bit w, input logic [7:0] a, input logic [31:0] d, input string r);
    @(posedge clk); #1;
    v[p] = 1'b1; we[p] = w; ad[p] = a; wd[p] = d;
    do @(negedge clk); while (!rdy[p]);
    @(posedge clk); #1;
    v[p] = 1'b0;
    if (w) expm[a] = d;
    @(negedge clk);
    chk(rv[p] === 1'b1, r, {31'b0, rv[p]}, 32'd1);
    chk(rd[p] === (w ? 32'd0 : expm[a]), r, rd[p], w ? 32'd0 : expm[a]);
    @(negedge clk);
    chk(rv[p] === 1'b0, "R2", {31'b0, rv[p]}, 32'd0);
  endtask

  task automatic probe(input int p, input logic [7:0] a, input bit exp_hit, input string r);
    @(posedge clk); #1;
    v[0] = 1'b1; we[0] = 1'b1; ad[0] = 8'hF8; wd[0] = 32'hDEAD;
    v[p] = 1'b1; we[p] = 1'b0; ad[p] = a;
    @(negedge clk);
    chk(rdy[p] === exp_hit, r, {31'b0, rdy[p]}, {31'b0, exp_hit});
    if (rdy[p]) begin
      @(posedge clk); #1;
      v[0] = 1'b0; v[p] = 1'b0;
    end else begin
      @(posedge clk); #1;
      v[0] = 1'b0;
      do @(negedge clk); while (!rdy[p]);
      @(posedge clk); #1;
      v[p] = 1'b0;
    end
    @(negedge clk);
    chk(rv[p] === 1'b1 && rd[p] === expm[a], r, rd[p], expm[a]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rv === 3'b000, "R1", {29'b0, rv}, 32'd0);
    probe(2, 8'h10, 1'b0, "R1");
  endtask

  task automatic t_fill;
    probe(2, 8'h15, 1'b1, "R3");
    go(2, 1'b0, 8'h17, 32'd0, "R2");
  endtask

  task automatic t_share;
    probe(1, 8'h12, 1'b0, "R4");
    @(posedge clk); #1;
    v[0] = 1'b1; we[0] = 1'b1; ad[0] = 8'hF8;
    v[1] = 1'b1; we[1] = 1'b0; ad[1] = 8'h11;
    v[2] = 1'b1; we[2] = 1'b0; ad[2] = 8'h13;
    @(negedge clk);
    chk(rdy === 3'b111, "R4", {29'b0, rdy}, 32'd7);
    @(posedge clk); #1;
    v = '0;
    @(negedge clk);
    chk(rd[1] === expm[8'h11] && rd[2] === expm[8'h13], "R4", rd[2], expm[8'h13]);
  endtask

  task automatic t_invalidate;
    go(0, 1'b1, 8'h14, 32'd20, "R5");
    go(1, 1'b0, 8'h14, 32'd0, "R5");
    go(2, 1'b0, 8'h14, 32'd0, "R5");
    go(0, 1'b1, 8'h14, 32'd40, "R6");
    probe(1, 8'h14, 1'b0, "R6");
    probe(2, 8'h14, 1'b0, "R6");
  endtask

  task automatic t_no_alloc_and_own;
    go(1, 1'b1, 8'h40, 32'h0000ABCD, "R5");
    go(2, 1'b0, 8'h40, 32'd0, "R5");
    probe(1, 8'h41, 1'b0, "R8");
    go(1, 1'b1, 8'h42, 32'h77, "R7");
    probe(1, 8'h42, 1'b1, "R7");
    probe(2, 8'h40, 1'b0, "R6");
  endtask

  task automatic t_false_share;
    go(1, 1'b0, 8'h2D, 32'd0, "R9");
    go(2, 1'b1, 8'h28, 32'h55, "R9");
    probe(1, 8'h2D, 1'b0, "R9");
  endtask

  task automatic t_replace;
    go(1, 1'b0, 8'h00, 32'd0, "R12");
    probe(1, 8'h41, 1'b0, "R12");
    probe(1, 8'h02, 1'b0, "R12");
  endtask

  task automatic t_priority;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      v[i] = 1'b1; we[i] = 1'b1; ad[i] = 8'h30 + 8'(i); wd[i] = 32'h100 + 32'(i);
      expm[8'h30 + 8'(i)] = 32'h100 + 32'(i);
    end
    @(negedge clk);
    chk(rdy === 3'b001, "R10", {29'b0, rdy}, 32'd1);
    @(posedge clk); #1; v[0] = 1'b0;
    @(negedge clk);
    chk(rdy === 3'b010 && rv === 3'b001, "R10", {29'b0, rdy}, 32'd2);
    @(posedge clk); #1; v[1] = 1'b0;
    @(negedge clk);
    chk(rdy === 3'b100 && rv === 3'b010, "R10", {29'b0, rdy}, 32'd4);
    @(posedge clk); #1; v[2] = 1'b0;
    @(negedge clk);
    chk(rv === 3'b100, "R10", {29'b0, rv}, 32'd4);
    go(1, 1'b0, 8'h32, 32'd0, "R10");
  endtask

  task automatic t_same_cycle;
    go(1, 1'b0, 8'h19, 32'd0, "R11");
    @(posedge clk); #1;
    v[0] = 1'b1; we[0] = 1'b1; ad[0] = 8'h1A; wd[0] = 32'h99;
    v[1] = 1'b1; we[1] = 1'b0; ad[1] = 8'h19;
    @(negedge clk);
    chk(rdy[1:0] === 2'b11, "R11", {30'b0, rdy[1:0]}, 32'd3);
    @(posedge clk); #1;
    v = '0;
    @(negedge clk);
    chk(rd[1] === expm[8'h19], "R11", rd[1], expm[8'h19]);
    expm[8'h1A] = 32'h99;
    probe(1, 8'h19, 1'b0, "R11");
    probe(1, 8'h1A, 1'b1, "R11");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) expm[i] = 32'(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_fill;
    t_share;
    t_invalidate;
    t_no_alloc_and_own;
    t_false_share;
    t_replace;
    t_priority;
    t_same_cycle;
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule